// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block steps one DMA channel through the bus states of a single-address transfer between memory and an I/O device. A one-cycle start pulse while idle captures a 16-bit start address, a word count, the transfer type, the timing mode and the step direction. The block then runs transfers back to back until the count runs out or an external end-of-process request arrives. During a service it holds the address enable high. It drives the low address byte on dedicated pins. It also generates the memory and I/O read and write strobes that the chosen transfer type calls for.

The upper address byte has no pins of its own. It is placed on an 8-bit data bus during a dedicated high-byte state (S1), together with an address strobe, so that an external latch can hold it. S1 runs at the start of every service, and after that only when stepping the address carries or borrows into the upper byte. This keeps long sequential services at the S2/S3/S4 rate. A compressed timing mode drops S3, which shortens a transfer to two clocks and makes the read pulse as wide as the write pulse.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset and whenever no service runs, aen, adstb, db_oe, memr, memw, ior, iow and tc are all low.
- R2: A start pulse while idle loads init_addr, init_count, xfer_type, compress and dir_dec. The first cycle of the service is S1, in which adstb and db_oe are high for exactly one cycle and db_out carries address bits 15:8. aen stays high from S1 until the service ends. A start pulse during a service has no effect.
- R3: Between transfers S1 runs again only when the next address differs from the current one in bits 15:8, that is on a carry out of bit 7 when counting up or a borrow into bit 7 when counting down. Otherwise the next transfer begins directly with S2.
- R4: xfer_type 2'b01 (write) asserts ior and memw; xfer_type 2'b10 (read) asserts memr and iow. Read strobes are high in S3, wait states and S4. Write strobes are high in wait states and S4.
- R5: xfer_type 2'b00 or 2'b11 (verify) runs the same state sequence with all four strobes low, and ready has no effect on it.
- R6: Without compress, a transfer takes three cycles (S2, S3, S4). With compress, it takes two cycles (S2, S4), and the read strobe and the write strobe are each high for the same number of cycles.
- R7: For read and write transfers, ready low at the clock edge leaving S3 (normal) or S2 (compressed) inserts wait cycles, one per edge at which ready is low, before S4.
- R8: After each transfer the address steps by +1 (dir_dec=0) or -1 (dir_dec=1). addr_lo carries address bits 7:0 during the transfer.
- R9: A service loaded with count N performs N+1 transfers. tc is high only during S4 of the transfer in which the count is 0, and the service then ends.
- R10: eop high at any clock edge during S1, S2, S3, a wait state or S4 of a transfer ends the service after that transfer's S4, with tc low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a service (sampled while idle) |
| init_addr | input | 16 | Start address of the service |
| init_count | input | 16 | Word count; N gives N+1 transfers |
| xfer_type | input | 2 | 00 verify, 01 write, 10 read, 11 verify |
| compress | input | 1 | Two-clock transfers when high |
| dir_dec | input | 1 | 1 steps the address down, 0 up |
| ready | input | 1 | Device ready; low inserts wait states |
| eop | input | 1 | External end-of-process request |
| aen | output | 1 | Address enable, high throughout a service |
| adstb | output | 1 | Address strobe for the upper-byte latch |
| db_oe | output | 1 | Data bus drive enable during S1 |
| db_out | output | 8 | Upper address byte during S1, else zero |
| addr_lo | output | 8 | Lower address byte |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count, high in the final S4 |

## Verification
The checker watches, on every cycle, the properties that do not depend on history. Strobe pairs that must never coincide stay exclusive. The address strobe is a single-cycle pulse that comes with the bus drive and the address enable. Every service opens with S1. Verify transfers stay silent. A terminal count always closes the service. Cycle counts per transfer, the number of wait states, the places where S1 recurs at a byte boundary, the address sequence recovered through a modelled external latch, and the effect of end-of-process or of a start pulse during a service depend on whole services. Only the bench's directed scenarios show these.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HI   = 3'd1,   // S1: upper address byte on the data bus
        ST_ADR  = 3'd2,   // S2: address presented
        ST_EXT  = 3'd3,   // S3: read pulse extension
        ST_WAIT = 3'd4,   // wait state
        ST_XFR  = 3'd5    // S4: read/write completes
    } dma_state_e;

    typedef enum logic [1:0] {
        XF_VERIFY  = 2'b00,
        XF_WRITE   = 2'b01,
        XF_READ    = 2'b10,
        XF_VERIFY2 = 2'b11
    } dma_xfer_e;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              step_down,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              hi_change
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        nxt_addr  = step_down ? (cur_addr - ADDR_ONE) : (cur_addr + ADDR_ONE);
        hi_change = (nxt_addr[ADDR_W-1:LO_W] != cur_addr[ADDR_W-1:LO_W]);
    end
endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
    import dma_seq_pkg::*;
(
    input  dma_state_e st,
    input  dma_xfer_e  xt,
    output logic       aen,
    output logic       adstb,
    output logic       memr,
    output logic       memw,
    output logic       ior,
    output logic       iow
);
    logic rd_phase;
    logic wr_phase;

    always_comb begin
        rd_phase = (st == ST_EXT) || (st == ST_WAIT) || (st == ST_XFR);
        wr_phase = (st == ST_WAIT) || (st == ST_XFR);
        aen      = (st != ST_IDLE);
        adstb    = (st == ST_HI);
        memr     = (xt == XF_READ)  && rd_phase;
        iow      = (xt == XF_READ)  && wr_phase;
        ior      = (xt == XF_WRITE) && rd_phase;
        memw     = (xt == XF_WRITE) && wr_phase;
    end
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [CNT_W-1:0]  init_count,
    input  logic [1:0]        xfer_type,
    input  logic              compress,
    input  logic              dir_dec,
    input  logic              ready,
    input  logic              eop,
    output logic              aen,
    output logic              adstb,
    output logic              db_oe,
    output logic [ADDR_W-LO_W-1:0] db_out,
    output logic [LO_W-1:0]   addr_lo,
    output logic              memr,
    output logic              memw,
    output logic              ior,
    output logic              iow,
    output logic              tc
);
    localparam int HI_W = ADDR_W - LO_W;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        dma_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        dma_xfer_e         xt;
        logic              cmp;
        logic              dec;
        logic              eop_seen;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] addr_nxt;
    logic              hi_change;
    logic              last_xfer;
    logic              uses_ready;
    dma_state_e        st_cur;
    dma_xfer_e         xt_cur;

    dma_addr_step #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_step (
        .cur_addr  (seq_q.addr),
        .step_down (seq_q.dec),
        .nxt_addr  (addr_nxt),
        .hi_change (hi_change)
    );

    dma_strobe_dec u_dec (
        .st    (seq_q.st),
        .xt    (seq_q.xt),
        .aen   (aen),
        .adstb (adstb),
        .memr  (memr),
        .memw  (memw),
        .ior   (ior),
        .iow   (iow)
    );

    always_comb begin
        seq_d      = seq_q;
        last_xfer  = (seq_q.cnt == '0);
        uses_ready = (seq_q.xt == XF_READ) || (seq_q.xt == XF_WRITE);

        if (seq_q.st != ST_IDLE && eop) begin
            seq_d.eop_seen = 1'b1;
        end

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st       = ST_HI;
                    seq_d.addr     = init_addr;
                    seq_d.cnt      = init_count;
                    seq_d.xt       = dma_xfer_e'(xfer_type);
                    seq_d.cmp      = compress;
                    seq_d.dec      = dir_dec;
                    seq_d.eop_seen = 1'b0;
                end
            end
            ST_HI: seq_d.st = ST_ADR;
            ST_ADR: begin
                if (!seq_q.cmp) begin
                    seq_d.st = ST_EXT;
                end else if (uses_ready && !ready) begin
                    seq_d.st = ST_WAIT;
                end else begin
                    seq_d.st = ST_XFR;
                end
            end
            ST_EXT: begin
                if (uses_ready && !ready) begin
                    seq_d.st = ST_WAIT;
                end else begin
                    seq_d.st = ST_XFR;
                end
            end
            ST_WAIT: begin
                if (ready) begin
                    seq_d.st = ST_XFR;
                end
            end
            ST_XFR: begin
                seq_d.addr = addr_nxt;
                seq_d.cnt  = seq_q.cnt - CNT_ONE;
                if (last_xfer || seq_q.eop_seen || eop) begin
                    seq_d.st = ST_IDLE;
                end else if (hi_change) begin
                    seq_d.st = ST_HI;
                end else begin
                    seq_d.st = ST_ADR;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, cnt: '0, xt: XF_VERIFY,
                       cmp: 1'b0, dec: 1'b0, eop_seen: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_cur  = seq_q.st;
    assign xt_cur  = seq_q.xt;
    assign db_oe   = (seq_q.st == ST_HI);
    assign db_out  = (seq_q.st == ST_HI) ? seq_q.addr[ADDR_W-1:LO_W] : {HI_W{1'b0}};
    assign addr_lo = seq_q.addr[LO_W-1:0];
    assign tc      = (seq_q.st == ST_XFR) && last_xfer;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       aen,
    input logic       adstb,
    input logic       db_oe,
    input logic       memr,
    input logic       memw,
    input logic       ior,
    input logic       iow,
    input logic       tc,
    input dma_xfer_e  xt_cur
);
    // R4
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(memr && memw) && !(ior && iow));

    // R4
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(memr && ior) && !(memw && iow));

    // R2
    adstb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |=> !adstb);

    // R2
    adstb_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |-> (aen && db_oe));

    // R2
    svc_opens_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aen) |-> adstb);

    // R5
    verify_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aen && (xt_cur == XF_VERIFY || xt_cur == XF_VERIFY2))
            |-> !(memr || memw || ior || iow));

    // R9
    tc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !aen);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aen |-> !(adstb || db_oe || memr || memw || ior || iow || tc));
endmodule

bind dma_cycle_seq dma_seq_chk u_seq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .aen    (aen),
    .adstb  (adstb),
    .db_oe  (db_oe),
    .memr   (memr),
    .memw   (memw),
    .ior    (ior),
    .iow    (iow),
    .tc     (tc),
    .xt_cur (xt_cur)
);

// File: tb/test_dma_cycle_seq.sv
module test_dma_cycle_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] init_addr = '0;
    logic [15:0] init_count = '0;
    logic [1:0]  xfer_type = '0;
    logic        compress = 1'b0;
    logic        dir_dec = 1'b0;
    logic        ready = 1'b1;
    logic        eop = 1'b0;
    logic        aen, adstb, db_oe, memr, memw, ior, iow, tc;
    logic [7:0]  db_out, addr_lo;

    int errors = 0;
    int checks = 0;

    // results of the last service
    int busy, n_stb, n_memr, n_memw, n_ior, n_iow, n_tc, n_xfer, tc_last, bad_oe;
    logic [7:0]  hi_seen [4];
    logic [15:0] first_addr, last_addr;

    dma_cycle_seq i_dma_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .init_addr(init_addr),
        .init_count(init_count), .xfer_type(xfer_type), .compress(compress),
        .dir_dec(dir_dec), .ready(ready), .eop(eop), .aen(aen), .adstb(adstb),
        .db_oe(db_oe), .db_out(db_out), .addr_lo(addr_lo), .memr(memr),
        .memw(memw), .ior(ior), .iow(iow), .tc(tc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, {aen, adstb, db_oe, memr, memw, ior, iow, tc}, 0);
    endtask

    task automatic run_svc(input logic [15:0] a, input logic [15:0] c,
                           input logic [1:0] t, input logic cm, input logic dn,
                           input int rdy_low, input int eop_at, input int restart_at);
        logic [7:0] latch;
        logic       prev_wr;
        busy = 0; n_stb = 0; n_memr = 0; n_memw = 0; n_ior = 0; n_iow = 0;
        n_tc = 0; n_xfer = 0; tc_last = 0; bad_oe = 0; latch = '0; prev_wr = 0;
        first_addr = '0; last_addr = '0;
        for (int k = 0; k < 4; k++) hi_seen[k] = '0;
        @(negedge clk);
        init_addr = a; init_count = c; xfer_type = t; compress = cm; dir_dec = dn;
        ready = (rdy_low == 0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (aen && busy < 5000) begin
            busy++;
            tc_last = tc;
            if (adstb) begin
                latch = db_out;
                if (!db_oe) bad_oe++;
                if (n_stb < 4) hi_seen[n_stb] = db_out;
                n_stb++;
            end
            if (memr) n_memr++;
            if (memw) n_memw++;
            if (ior)  n_ior++;
            if (iow)  n_iow++;
            if (tc)   n_tc++;
            if ((memw || iow) && !prev_wr) begin
                if (n_xfer == 0) first_addr = {latch, addr_lo};
                last_addr = {latch, addr_lo};
                n_xfer++;
            end
            prev_wr = memw || iow;
            ready = (busy >= rdy_low);
            eop   = (busy == eop_at);
            if (busy == restart_at) begin
                start = 1'b1; init_addr = ~a; init_count = 16'h0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; eop = 1'b0; ready = 1'b1;
    endtask

    task automatic t_reset;
        check_idle("R1 reset outputs");
    endtask

    task automatic t_read_normal;
        run_svc(16'h00FE, 16'd3, 2'b10, 1'b0, 1'b0, 0, -1, -1);
        chk("R6 busy cycles normal read", busy, 14);
        chk("R3 adstb count on carry", n_stb, 2);
        chk("R2 first upper byte", hi_seen[0], 8'h00);
        chk("R3 second upper byte", hi_seen[1], 8'h01);
        chk("R2 db_oe with adstb", bad_oe, 0);
        chk("R4 memr cycles", n_memr, 8);
        chk("R4 iow cycles", n_iow, 4);
        chk("R4 no memw/ior on read", n_memw + n_ior, 0);
        chk("R8 first address", first_addr, 16'h00FE);
        chk("R8 last address", last_addr, 16'h0101);
        chk("R9 tc once", n_tc, 1);
        chk("R9 tc in final cycle", tc_last, 1);
        check_idle("R1 idle after service");
    endtask

    task automatic t_write_compressed;
        run_svc(16'h12FF, 16'd1, 2'b01, 1'b1, 1'b0, 0, -1, -1);
        chk("R6 busy cycles compressed write", busy, 6);
        chk("R3 adstb count compressed", n_stb, 2);
        chk("R4 ior cycles", n_ior, 2);
        chk("R4 memw cycles", n_memw, 2);
        chk("R4 no memr/iow on write", n_memr + n_iow, 0);
        chk("R8 first address write", first_addr, 16'h12FF);
        chk("R8 last address write", last_addr, 16'h1300);
    endtask

    task automatic t_read_compressed_dec;
        run_svc(16'h0080, 16'd2, 2'b10, 1'b1, 1'b1, 0, -1, -1);
        chk("R6 busy compressed read", busy, 7);
        chk("R3 no repeat S1 without borrow", n_stb, 1);
        chk("R6 read width equals write width", n_memr, n_iow);
        chk("R6 memr one per transfer", n_memr, 3);
        chk("R8 last address down", last_addr, 16'h007E);
    endtask

    task automatic t_verify_dec;
        run_svc(16'h0101, 16'd2, 2'b00, 1'b0, 1'b1, 50, -1, -1);
        chk("R5 verify busy ignores ready", busy, 11);
        chk("R5 verify strobes", n_memr + n_memw + n_ior + n_iow, 0);
        chk("R3 adstb on borrow", n_stb, 2);
        chk("R3 upper byte after borrow", hi_seen[1], 8'h00);
        chk("R9 verify tc", n_tc, 1);
        run_svc(16'h0300, 16'd0, 2'b11, 1'b1, 1'b0, 50, -1, -1);
        chk("R5 type 11 busy compressed", busy, 3);
        chk("R5 type 11 strobes", n_memr + n_memw + n_ior + n_iow, 0);
    endtask

    task automatic t_wait_states;
        run_svc(16'h4000, 16'd0, 2'b10, 1'b0, 1'b0, 6, -1, -1);
        chk("R7 busy with waits normal", busy, 7);
        chk("R7 memr stretched", n_memr, 5);
        chk("R7 iow stretched", n_iow, 4);
        run_svc(16'h4000, 16'd0, 2'b01, 1'b1, 1'b0, 6, -1, -1);
        chk("R7 busy with waits compressed", busy, 7);
        chk("R7 ior stretched", n_ior, 5);
        chk("R6 compressed widths equal", n_memw, n_ior);
    endtask

    task automatic t_eop;
        run_svc(16'h2000, 16'd100, 2'b10, 1'b0, 1'b0, 0, 5, -1);
        chk("R10 busy after eop", busy, 7);
        chk("R10 transfers after eop", n_xfer, 2);
        chk("R10 no tc on eop", n_tc, 0);
        chk("R10 last address", last_addr, 16'h2001);
    endtask

    task automatic t_restart_ignored;
        run_svc(16'h00FE, 16'd3, 2'b10, 1'b0, 1'b0, 0, -1, 3);
        chk("R2 restart ignored busy", busy, 14);
        chk("R2 restart ignored last addr", last_addr, 16'h0101);
        chk("R2 restart ignored transfers", n_xfer, 4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_normal();
        t_write_compressed();
        t_read_compressed_dec();
        t_verify_dec();
        t_wait_states();
        t_eop();
        t_restart_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule